// File: doc/BRIEF.md
# Snooping Write-Invalidate Cache Controller

This block is the cache-side coherence controller for one processor in a small multicore whose caches share a broadcast bus. It holds a direct-mapped cache of one-word lines. Each line carries one of three states: INVALID, CLEAN (a shared read copy) or DIRTY (the only copy, owned by this cache). It serves loads and stores from its processor. When a store needs ownership, it puts the address on the bus. A second lookup port watches the requests that other caches broadcast. On a match it invalidates or downgrades its own copy, and it writes a dirty value back to memory first.

The line index is the low `log2(LINES)` address bits and the tag is the remaining upper bits. A request is taken on a cycle where `cpu_req` is high and `cpu_busy` is low. Read data comes back with a one-cycle `cpu_rvalid` pulse. The controller sequences through these states:
- IDLE: serves hits and accepts requests.
- EVICT: writes back a dirty victim.
- ARB: requests the bus and waits for the grant.
- BCAST: broadcasts the address and command.
- FETCH: waits for memory data.
- FILL: installs the line and answers reads.

The transitions are:
- IDLE to EVICT: a miss whose victim is dirty.
- IDLE to ARB: any other miss, or a store to a clean line.
- EVICT to ARB: the write-back port is free.
- ARB to BCAST: grant received.
- BCAST to FETCH: the line is no longer valid for the request address.
- BCAST to FILL: the line is still valid.
- FETCH to FILL: memory data is valid.
- FILL to IDLE: always.

`bus_req` stays high from ARB through FILL. The bus is expected to issue no other broadcast while it is held.

Top module: `snoop_inv_ctrl`

## Requirements
- R1: After reset every line is INVALID, and `cpu_busy`, `cpu_rvalid`, `bus_req`, `mem_rd_en` and `mem_wb_en` are low. The first load of any address therefore misses.
- R2: A load that misses raises `bus_req`, broadcasts the address with `bus_cmd_write`=0, fetches the word over the memory read port, installs the line CLEAN and returns the fetched word with `cpu_rvalid`.
- R3: A load that hits a CLEAN or DIRTY line pulses `cpu_rvalid` in the cycle after acceptance with the cached word and raises no `bus_req`.
- R4: A store to a DIRTY line updates the word without using the bus. A store to an INVALID line broadcasts with `bus_cmd_write`=1, fetches the word and then installs the store data as DIRTY. A store to a CLEAN line broadcasts with `bus_cmd_write`=1 and becomes DIRTY with no fetch.
- R5: A snooped remote write (`snp_write`=1) that matches a DIRTY line drives `mem_wb_en` in the same cycle with the snooped address and the line's word, then makes the line INVALID. If it matches a CLEAN line, the line becomes INVALID with no write-back.
- R6: A snooped remote read (`snp_write`=0) that matches a DIRTY line writes the word back in the same cycle and leaves the line CLEAN. If it matches a CLEAN line, nothing changes.
- R7: A miss whose victim line is DIRTY writes the victim's address and word back before the bus request and the fetch of the new word.
- R8: If a snoop invalidates the line of a pending store to a CLEAN line before the grant arrives, the store is restarted as a store to an INVALID line and performs a fetch.
- R9: `cpu_busy` is high while the controller is outside IDLE. It is also high in any cycle where `snp_valid` is high and `snp_addr` selects the same index as `cpu_addr`.
- R10: A snoop write-back has priority on the write-back port. An eviction in the same cycle waits one cycle and then writes back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Store data |
| cpu_busy | output | 1 | Request cannot be accepted this cycle |
| cpu_rvalid | output | 1 | Load data valid pulse |
| cpu_rdata | output | DATA_W | Load data |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant pulse |
| bus_cmd_valid | output | 1 | Broadcast valid |
| bus_cmd_write | output | 1 | Broadcast is an ownership (write) request |
| bus_cmd_addr | output | ADDR_W | Broadcast address |
| snp_valid | input | 1 | Remote request observed on the bus |
| snp_write | input | 1 | Remote request is a write |
| snp_addr | input | ADDR_W | Remote request address |
| mem_rd_en | output | 1 | Memory fetch request, held until data is valid |
| mem_rd_addr | output | ADDR_W | Fetch address |
| mem_rd_valid | input | 1 | Fetch data valid |
| mem_rd_data | input | DATA_W | Fetch data |
| mem_wb_en | output | 1 | Write-back strobe |
| mem_wb_addr | output | ADDR_W | Write-back address |
| mem_wb_data | output | DATA_W | Write-back data |

## Verification
Two pairs of functions can meet in one cycle.

The first pair is a snoop and a processor access to the same index. The bench drives a snoop whose index equals that of `cpu_addr` and expects `cpu_busy` high. It then moves the snoop to another index and expects `cpu_busy` low.

The second pair is a snoop write-back and an eviction. The bench issues a load that evicts a dirty victim. In the very cycle the controller sits in EVICT, it drives a remote read that matches another dirty line. The write-back port must carry the snooped line in that cycle and the victim in the next. The memory model then holds both values.

A third case is a snoop invalidation that lands while a store is still waiting for its grant. The bench judges it by counting one fetch and reading back the stored word.

// File: rtl/snoop_inv_pkg.sv
package snoop_inv_pkg;

    typedef enum logic [1:0] {
        LN_INV = 2'd0,
        LN_RC  = 2'd1,
        LN_WD  = 2'd2
    } line_st_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_EVICT,
        S_ARB,
        S_BCAST,
        S_FETCH,
        S_FILL
    } ctl_st_e;

endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
    import snoop_inv_pkg::*;
#(
    parameter int LINES  = 16,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    // processor port
    input  logic [IDX_W-1:0]  p_idx,
    output line_st_e          p_st,
    output logic [TAG_W-1:0]  p_tag,
    output logic [DATA_W-1:0] p_data,
    input  logic              p_we,
    input  line_st_e          p_wst,
    input  logic [TAG_W-1:0]  p_wtag,
    input  logic [DATA_W-1:0] p_wdata,
    // snoop port (state updates only)
    input  logic [IDX_W-1:0]  s_idx,
    output line_st_e          s_st,
    output logic [TAG_W-1:0]  s_tag,
    output logic [DATA_W-1:0] s_data,
    input  logic              s_we,
    input  line_st_e          s_wst
);

    line_st_e          st_q   [LINES];
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // state bits: the snoop port is applied last and wins on a shared index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LINES; i++) begin
                st_q[i] <= LN_INV;
            end
        end else begin
            if (p_we) begin
                st_q[p_idx] <= p_wst;
            end
            if (s_we) begin
                st_q[s_idx] <= s_wst;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (p_we) begin
            tag_q[p_idx]  <= p_wtag;
            data_q[p_idx] <= p_wdata;
        end
    end

    assign p_st   = st_q[p_idx];
    assign p_tag  = tag_q[p_idx];
    assign p_data = data_q[p_idx];
    assign s_st   = st_q[s_idx];
    assign s_tag  = tag_q[s_idx];
    assign s_data = data_q[s_idx];

endmodule

// File: rtl/coh_snoop_unit.sv
module coh_snoop_unit
    import snoop_inv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic [IDX_W-1:0]  s_idx,
    input  line_st_e          s_st,
    input  logic [TAG_W-1:0]  s_tag,
    input  logic [DATA_W-1:0] s_data,
    output logic              s_we,
    output line_st_e          s_wst,
    output logic              wb_en,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data
);

    logic hit;

    assign s_idx   = snp_addr[IDX_W-1:0];
    assign hit     = snp_valid && (s_st != LN_INV) && (s_tag == snp_addr[ADDR_W-1:IDX_W]);
    assign wb_addr = snp_addr;
    assign wb_data = s_data;

    always_comb begin
        s_we  = 1'b0;
        s_wst = s_st;
        wb_en = 1'b0;
        if (hit) begin
            if (snp_write) begin
                s_we  = 1'b1;
                s_wst = LN_INV;
                wb_en = (s_st == LN_WD);
            end else if (s_st == LN_WD) begin
                s_we  = 1'b1;
                s_wst = LN_RC;
                wb_en = 1'b1;
            end
        end
    end

endmodule

// File: rtl/snoop_inv_ctrl.sv
module snoop_inv_ctrl
    import snoop_inv_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINES  = 16,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_busy,
    output logic              cpu_rvalid,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic              bus_cmd_valid,
    output logic              bus_cmd_write,
    output logic [ADDR_W-1:0] bus_cmd_addr,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rd_valid,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic              mem_wb_en,
    output logic [ADDR_W-1:0] mem_wb_addr,
    output logic [DATA_W-1:0] mem_wb_data
);

    ctl_st_e state_q, state_d;

    logic [ADDR_W-1:0] req_addr_q;
    logic              req_we_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] fetched_q;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;

    // line store ports
    logic [IDX_W-1:0]  p_idx, s_idx;
    line_st_e          p_st, s_st, p_wst, s_wst;
    logic [TAG_W-1:0]  p_tag, s_tag, p_wtag, cur_tag;
    logic [DATA_W-1:0] p_data, s_data, p_wdata;
    logic              p_we, s_we;

    logic              snp_wb;
    logic [ADDR_W-1:0] snp_wb_addr;
    logic [DATA_W-1:0] snp_wb_data;

    logic p_hit, accept, snp_conflict, ev_wb;

    assign p_idx   = (state_q == S_IDLE) ? cpu_addr[IDX_W-1:0] : req_addr_q[IDX_W-1:0];
    assign cur_tag = (state_q == S_IDLE) ? cpu_addr[ADDR_W-1:IDX_W] : req_addr_q[ADDR_W-1:IDX_W];
    assign p_hit   = (p_st != LN_INV) && (p_tag == cur_tag);

    assign snp_conflict = snp_valid && (snp_addr[IDX_W-1:0] == cpu_addr[IDX_W-1:0]);
    assign cpu_busy     = (state_q != S_IDLE) || snp_conflict;
    assign accept       = cpu_req && !cpu_busy;

    coh_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .p_idx   (p_idx),
        .p_st    (p_st),
        .p_tag   (p_tag),
        .p_data  (p_data),
        .p_we    (p_we),
        .p_wst   (p_wst),
        .p_wtag  (p_wtag),
        .p_wdata (p_wdata),
        .s_idx   (s_idx),
        .s_st    (s_st),
        .s_tag   (s_tag),
        .s_data  (s_data),
        .s_we    (s_we),
        .s_wst   (s_wst)
    );

    coh_snoop_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) snoop_i (
        .snp_valid (snp_valid),
        .snp_write (snp_write),
        .snp_addr  (snp_addr),
        .s_idx     (s_idx),
        .s_st      (s_st),
        .s_tag     (s_tag),
        .s_data    (s_data),
        .s_we      (s_we),
        .s_wst     (s_wst),
        .wb_en     (snp_wb),
        .wb_addr   (snp_wb_addr),
        .wb_data   (snp_wb_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, line writes and bus/memory strobes
    always_comb begin
        state_d       = state_q;
        p_we          = 1'b0;
        p_wst         = p_st;
        p_wtag        = p_tag;
        p_wdata       = p_data;
        bus_req       = 1'b0;
        bus_cmd_valid = 1'b0;
        mem_rd_en     = 1'b0;
        ev_wb         = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (p_hit && !cpu_we) begin
                        state_d = S_IDLE;
                    end else if (p_hit && p_st == LN_WD) begin
                        p_we    = 1'b1;
                        p_wdata = cpu_wdata;
                    end else if (!p_hit && p_st == LN_WD) begin
                        state_d = S_EVICT;
                    end else begin
                        state_d = S_ARB;
                    end
                end
            end
            S_EVICT: begin
                if (!snp_wb) begin
                    ev_wb   = 1'b1;
                    p_we    = 1'b1;
                    p_wst   = LN_INV;
                    state_d = S_ARB;
                end
            end
            S_ARB: begin
                bus_req = 1'b1;
                if (bus_gnt) begin
                    state_d = S_BCAST;
                end
            end
            S_BCAST: begin
                bus_req       = 1'b1;
                bus_cmd_valid = 1'b1;
                state_d       = p_hit ? S_FILL : S_FETCH;
            end
            S_FETCH: begin
                bus_req   = 1'b1;
                mem_rd_en = 1'b1;
                if (mem_rd_valid) begin
                    state_d = S_FILL;
                end
            end
            S_FILL: begin
                bus_req = 1'b1;
                p_we    = 1'b1;
                p_wtag  = req_addr_q[ADDR_W-1:IDX_W];
                p_wst   = req_we_q ? LN_WD : LN_RC;
                p_wdata = req_we_q ? req_wdata_q : fetched_q;
                state_d = S_IDLE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // request latch and response registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            req_we_q    <= 1'b0;
            req_wdata_q <= '0;
            fetched_q   <= '0;
            rvalid_q    <= 1'b0;
            rdata_q     <= '0;
        end else begin
            rvalid_q <= 1'b0;
            if (accept) begin
                req_addr_q  <= cpu_addr;
                req_we_q    <= cpu_we;
                req_wdata_q <= cpu_wdata;
                if (p_hit && !cpu_we) begin
                    rvalid_q <= 1'b1;
                    rdata_q  <= p_data;
                end
            end
            if (state_q == S_FETCH && mem_rd_valid) begin
                fetched_q <= mem_rd_data;
            end
            if (state_q == S_FILL && !req_we_q) begin
                rvalid_q <= 1'b1;
                rdata_q  <= fetched_q;
            end
        end
    end

    assign cpu_rvalid    = rvalid_q;
    assign cpu_rdata     = rdata_q;
    assign bus_cmd_write = req_we_q;
    assign bus_cmd_addr  = req_addr_q;
    assign mem_rd_addr   = req_addr_q;
    assign mem_wb_en     = snp_wb || ev_wb;
    assign mem_wb_addr   = snp_wb ? snp_wb_addr : {p_tag, req_addr_q[IDX_W-1:0]};
    assign mem_wb_data   = snp_wb ? snp_wb_data : p_data;

endmodule

// File: rtl/snoop_inv_ctrl_chk.sv
module snoop_inv_ctrl_chk
    import snoop_inv_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_cmd_valid,
    input logic              mem_rd_en,
    input logic              cpu_busy,
    input logic              mem_wb_en,
    input logic [ADDR_W-1:0] mem_wb_addr,
    input logic [ADDR_W-1:0] snp_addr,
    input logic              snp_wb,
    input ctl_st_e           fsm_q
);

    // R2
    bcast_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cmd_valid |-> bus_req);

    // R2
    fetch_owns_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> bus_req);

    // R9
    busy_on_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> cpu_busy);

    // R10
    snoop_wb_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_wb |-> (mem_wb_en && mem_wb_addr == snp_addr));

    // R10
    evict_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == S_EVICT && snp_wb) |=> (fsm_q == S_EVICT));

endmodule

bind snoop_inv_ctrl snoop_inv_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_cmd_valid (bus_cmd_valid),
    .mem_rd_en     (mem_rd_en),
    .cpu_busy      (cpu_busy),
    .mem_wb_en     (mem_wb_en),
    .mem_wb_addr   (mem_wb_addr),
    .snp_addr      (snp_addr),
    .snp_wb        (snp_wb),
    .fsm_q         (state_q)
);

// File: tb/snoop_inv_ctrl_tb.sv
`timescale 1ns/1ps
module snoop_inv_ctrl_tb_top;

    localparam int AW = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_req = 1'b0, cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_busy, cpu_rvalid;
    logic [DW-1:0] cpu_rdata;
    logic          bus_req, bus_gnt = 1'b0, bus_cmd_valid, bus_cmd_write;
    logic [AW-1:0] bus_cmd_addr;
    logic          snp_valid = 1'b0, snp_write = 1'b0;
    logic [AW-1:0] snp_addr = '0;
    logic          mem_rd_en, mem_rd_valid = 1'b0;
    logic [AW-1:0] mem_rd_addr;
    logic [DW-1:0] mem_rd_data;
    logic          mem_wb_en;
    logic [AW-1:0] mem_wb_addr;
    logic [DW-1:0] mem_wb_data;

    always #2.5 clk = ~clk;

    snoop_inv_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(16)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd_valid(bus_cmd_valid),
        .bus_cmd_write(bus_cmd_write), .bus_cmd_addr(bus_cmd_addr),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data),
        .mem_wb_en(mem_wb_en), .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data)
    );

    // ---------------- memory, bus and activity logging ----------------
    logic [DW-1:0] mem [256];
    int  cyc = 0, wb_cnt = 0, rd_cnt = 0, bc_cnt = 0, breq_cnt = 0;
    int  wb_cyc = 0, rd_cyc = 0;
    logic [AW-1:0] bc_addr = '0;
    logic bc_we = 1'b0;
    logic gnt_block = 1'b0, gnt_given = 1'b0;

    function automatic logic [DW-1:0] init_val(input int a);
        return 32'hA000_0000 + 32'(a * 7);
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    end

    assign mem_rd_data = mem[mem_rd_addr];

    always @(posedge clk) begin
        cyc++;
        if (mem_wb_en) begin
            mem[mem_wb_addr] <= mem_wb_data;
            wb_cnt++;
            wb_cyc = cyc;
        end
        if (mem_rd_en && mem_rd_valid) begin
            rd_cnt++;
            rd_cyc = cyc;
        end
        mem_rd_valid <= mem_rd_en && !mem_rd_valid;
        if (bus_cmd_valid) begin
            bc_cnt++;
            bc_addr = bus_cmd_addr;
            bc_we   = bus_cmd_write;
        end
        if (bus_req) breq_cnt++;
        bus_gnt <= 1'b0;
        if (!bus_req) gnt_given <= 1'b0;
        else if (!gnt_given && !gnt_block) begin
            bus_gnt   <= 1'b1;
            gnt_given <= 1'b1;
        end
    end

    // ---------------- checking ----------------
    int n_checks = 0, n_errors = 0;

    task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: expected load data
    logic [DW-1:0] exp_q [$];
    string         tag_q [$];

    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (cpu_rvalid) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected rvalid", cpu_rdata, '0);
                end else begin
                    automatic logic [DW-1:0] e = exp_q.pop_front();
                    automatic string t = tag_q.pop_front();
                    chk(cpu_rdata === e, t, cpu_rdata, e);
                end
            end
        end
    end

    bit op_done = 1'b0;

    task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [DW-1:0] exp, input string req);
        op_done = 1'b0;
        if (!we) begin
            exp_q.push_back(exp);
            tag_q.push_back(req);
        end
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        #1;
        while (cpu_busy) begin @(negedge clk); #1; end
        @(posedge clk);
        @(negedge clk);
        cpu_req = 1'b0;
        #1;
        while (cpu_busy) begin @(negedge clk); #1; end
        @(negedge clk);
        #3;
        op_done = 1'b1;
    endtask

    logic          sw_en;
    logic [AW-1:0] sw_addr;
    logic [DW-1:0] sw_data;

    task automatic snoop(input bit w, input logic [AW-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_write = w; snp_addr = a;
        #1;
        sw_en = mem_wb_en; sw_addr = mem_wb_addr; sw_data = mem_wb_data;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        #500000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    // ---------------- stimulus ----------------
    localparam logic [AW-1:0] A = 8'h13, B = 8'h25, C = 8'h47, D = 8'h57, E = 8'h69;
    localparam logic [AW-1:0] G = 8'h21, H = 8'h12, G2 = 8'h31;

    initial begin
        int b0, r0, q0, w0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(!cpu_busy && !cpu_rvalid, "R1 busy/rvalid", {cpu_busy, cpu_rvalid}, 0);
        chk(!bus_req && !mem_rd_en && !mem_wb_en, "R1 bus/mem idle", {bus_req, mem_rd_en, mem_wb_en}, 0);

        // R2 load miss (R1: first access misses)
        b0 = bc_cnt; r0 = rd_cnt;
        cpu_op(0, A, '0, init_val(A), "R2 miss data");
        chk(bc_cnt == b0 + 1 && bc_we == 1'b0 && bc_addr == A, "R2 read broadcast", bc_addr, A);
        chk(rd_cnt == r0 + 1, "R1 R2 fetch count", rd_cnt, r0 + 1);

        // R3 load hit on CLEAN
        q0 = breq_cnt;
        cpu_op(0, A, '0, init_val(A), "R3 hit data");
        chk(breq_cnt == q0, "R3 no bus on hit", breq_cnt, q0);

        // R4 store to CLEAN: broadcast write, no fetch
        b0 = bc_cnt; r0 = rd_cnt;
        cpu_op(1, A, 32'h1111_0001, '0, "");
        chk(bc_cnt == b0 + 1 && bc_we == 1'b1, "R4 upgrade broadcast", bc_we, 1);
        chk(rd_cnt == r0, "R4 upgrade no fetch", rd_cnt, r0);
        // R4 store to DIRTY: local only
        q0 = breq_cnt;
        cpu_op(1, A, 32'h1111_0002, '0, "");
        cpu_op(0, A, '0, 32'h1111_0002, "R3 R4 dirty hit data");
        chk(breq_cnt == q0, "R4 dirty store no bus", breq_cnt, q0);

        // R4 store to INVALID: broadcast + fetch
        b0 = bc_cnt; r0 = rd_cnt;
        cpu_op(1, B, 32'h2222_0005, '0, "");
        chk(bc_we == 1'b1 && bc_addr == B && rd_cnt == r0 + 1, "R4 write miss fetch", rd_cnt, r0 + 1);

        // R6 remote read on DIRTY
        snoop(0, A);
        chk(sw_en && sw_addr == A && sw_data == 32'h1111_0002, "R6 snoop read write-back", sw_data, 32'h1111_0002);
        q0 = breq_cnt;
        cpu_op(0, A, '0, 32'h1111_0002, "R6 stays valid data");
        chk(breq_cnt == q0, "R6 stays valid", breq_cnt, q0);
        snoop(0, A);
        chk(!sw_en, "R6 clean no write-back", sw_en, 0);
        b0 = bc_cnt;
        cpu_op(1, A, 32'h1111_0003, '0, "");
        chk(bc_cnt == b0 + 1, "R6 downgraded to clean", bc_cnt, b0 + 1);

        // R5 remote write on DIRTY then CLEAN
        snoop(1, B);
        chk(sw_en && sw_addr == B && sw_data == 32'h2222_0005, "R5 dirty write-back", sw_data, 32'h2222_0005);
        r0 = rd_cnt;
        cpu_op(0, B, '0, 32'h2222_0005, "R5 refetch data");
        chk(rd_cnt == r0 + 1, "R5 dirty invalidated", rd_cnt, r0 + 1);
        snoop(1, B);
        chk(!sw_en, "R5 clean no write-back", sw_en, 0);
        r0 = rd_cnt;
        cpu_op(0, B, '0, 32'h2222_0005, "R5 clean refetch data");
        chk(rd_cnt == r0 + 1, "R5 clean invalidated", rd_cnt, r0 + 1);

        // R7 dirty victim replaced
        cpu_op(1, C, 32'h3333_0007, '0, "");
        w0 = wb_cnt;
        cpu_op(0, D, '0, init_val(D), "R7 new line data");
        chk(wb_cnt == w0 + 1 && mem[C] == 32'h3333_0007, "R7 victim written back", mem[C], 32'h3333_0007);
        chk(wb_cyc < rd_cyc, "R7 write-back before fetch", wb_cyc, rd_cyc);
        cpu_op(0, C, '0, 32'h3333_0007, "R7 victim readable");

        // R8 restart of a pending upgrade after snoop invalidation
        cpu_op(0, E, '0, init_val(E), "R8 setup data");
        r0 = rd_cnt;
        gnt_block = 1'b1;
        fork
            cpu_op(1, E, 32'h4444_0009, '0, "");
        join_none
        repeat (4) @(negedge clk);
        #1;
        chk(cpu_busy && bus_req, "R9 busy while waiting grant", {cpu_busy, bus_req}, 2'b11);
        snoop(1, E);
        chk(!sw_en, "R5 clean invalidate during wait", sw_en, 0);
        gnt_block = 1'b0;
        wait (op_done);
        chk(rd_cnt == r0 + 1, "R8 restart fetches", rd_cnt, r0 + 1);
        cpu_op(0, E, '0, 32'h4444_0009, "R8 store kept");

        // R9 snoop index conflict
        @(negedge clk);
        cpu_addr = 8'h1B; snp_valid = 1'b1; snp_write = 1'b0; snp_addr = 8'h3B;
        #1;
        chk(cpu_busy, "R9 same index busy", cpu_busy, 1);
        snp_addr = 8'h3C;
        #1;
        chk(!cpu_busy, "R9 other index free", cpu_busy, 0);
        @(negedge clk);
        snp_valid = 1'b0;

        // R10 snoop write-back and eviction in the same cycle
        cpu_op(1, G, 32'h5555_0001, '0, "");
        cpu_op(1, H, 32'h6666_0002, '0, "");
        exp_q.push_back(init_val(G2));
        tag_q.push_back("R10 load data");
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = G2;
        @(negedge clk);
        cpu_req = 1'b0;
        snp_valid = 1'b1; snp_write = 1'b0; snp_addr = H;
        #1;
        chk(mem_wb_en && mem_wb_addr == H && mem_wb_data == 32'h6666_0002, "R10 snoop wins port", mem_wb_addr, H);
        @(negedge clk);
        snp_valid = 1'b0;
        #1;
        chk(mem_wb_en && mem_wb_addr == G && mem_wb_data == 32'h5555_0001, "R10 eviction next cycle", mem_wb_addr, G);
        #1;
        while (cpu_busy) begin @(negedge clk); #1; end
        @(negedge clk);
        #3;
        chk(mem[G] == 32'h5555_0001 && mem[H] == 32'h6666_0002, "R10 both values in memory", mem[G], 32'h5555_0001);

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R2 R3 all loads answered", exp_q.size(), 0);
        finish_run();
    end

endmodule